// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the slave side of a serial EEPROM on an SPI bus. It runs on a fast system clock and oversamples the bus pins. It takes commands in SPI mode 0 or mode 3 and decodes a command byte, followed by a 16-bit address where one is needed. It serves reads and writes through a byte-wide port to an external memory array. It keeps a small status register that holds a busy flag, a write-enable latch, two block-protect bits and a protect-enable bit.

Write data is collected into a page buffer. Programming starts only when chip select rises on a byte boundary. After that, the buffer is flushed to the memory port and a busy counter stands in for the self-timed programming cycle. A hold input can pause a transfer at any bit and resume it later without losing position. A write-protect input locks the status register while the protect-enable bit is set.

The command state machine has these states: `ST_CMD` (waiting for a command byte), `ST_ADDR_HI`, `ST_ADDR_LO`, `ST_READ`, `ST_STAT_RD`, `ST_STAT_WR`, `ST_DATA_IN` and `ST_SKIP` (drop the rest of the frame). Its transitions are:
- CS high in any state goes to `ST_CMD`.
- In `ST_CMD`, read-status goes to `ST_STAT_RD`.
- In `ST_CMD` while busy, any other command goes to `ST_SKIP`.
- In `ST_CMD`, read, or write with the latch set, goes to `ST_ADDR_HI`. `ST_ADDR_HI` then goes to `ST_ADDR_LO`.
- `ST_ADDR_LO` goes to `ST_READ` for a read and to `ST_DATA_IN` for a write.
- In `ST_CMD`, write-status with the latch set goes to `ST_STAT_WR`. After one byte, `ST_STAT_WR` goes to `ST_SKIP`.
- In `ST_CMD`, latch set/clear and unknown commands go to `ST_SKIP`.

Top module: `spi_eeprom_slave`

## Requirements
- R1: SI is sampled on rising SCK edges and SO changes on falling SCK edges. Both mode 0 (SCK idles low) and mode 3 (SCK idles high) give the same results.
- R2: While CS is high, the block is deselected. In that state so_oe is 0 and the bit counter returns to zero, so each selection starts on a fresh byte.
- R3: The command bytes are 0x06 (set write-enable latch), 0x04 (clear latch), 0x05 (read status), 0x01 (write status), 0x03 (read) and 0x02 (write). The status byte is bit7 protect-enable, bits 3:2 block-protect, bit1 write-enable latch and bit0 busy; all other bits read 0.
- R4: A read takes a 16-bit address, MSB first, and then streams bytes MSB first. The address increments after each byte and wraps from the last array byte to address 0.
- R5: A write command with the latch clear is ignored and changes no memory byte.
- R6: Write data fills a page buffer; the low six address bits wrap inside the 64-byte page. Programming starts on the CS rise only after a whole number of data bytes. A CS rise in the middle of a byte writes nothing and leaves the latch set.
- R7: During the programming cycle, the busy bit reads 1 and every command except read status is ignored. When the cycle ends, the latch clears.
- R8: The block-protect code 00 protects nothing, 01 protects the upper quarter, 10 the upper half and 11 the whole array. Protected bytes are dropped from a write.
- R9: Write status needs the latch set. It loads bit7 and bits 3:2 from the data byte and clears the latch.
- R10: When protect-enable is 1 and WP is low, write status is rejected and the latch stays set. When protect-enable is 0, WP has no effect.
- R11: HOLD low while SCK is low pauses the transfer. While paused, SCK and SI are ignored and so_oe is 0.
- R12: HOLD high while SCK is low resumes the transfer at the exact bit where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Status write protect, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| mem_addr | output | AW | Array byte address |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, combinational from mem_addr |

## Verification
The read path is tried three ways: a plain two-byte stream, a stream that crosses the array end, and a stream taken in mode 3. Together these separate wrong clock edges, a missing auto-increment and a wrong wrap point. Writes are tried with the latch clear, during busy, across a page end, with a trailing partial byte, and at each protect code on both sides of its boundary. Each of these tells apart a different gate on the page buffer. Status writes are tried under every combination of protect-enable and WP. A read paused mid-byte, with SCK toggling and SI held high during the pause, shows whether the bit position and data survive.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_READ,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_DATA_IN,
        ST_SKIP
    } cmd_state_t;

endpackage

// File: rtl/spi_eeprom_shift.sv
// Bus front end: SCK edge detection, hold/pause tracking, receive and transmit shifters.
module spi_eeprom_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic       hold_n,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic [2:0] bit_cnt,
    output logic       so,
    output logic       live
);
    logic       sck_q;
    logic       paused;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       rise;
    logic       fall;

    assign live = !cs_n && !paused;
    assign rise = live && sck && !sck_q;
    assign fall = live && !sck && sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            paused    <= 1'b0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
            so        <= 1'b0;
        end else begin
            sck_q     <= sck;
            byte_done <= 1'b0;
            if (cs_n) begin
                paused  <= 1'b0;
                bit_cnt <= '0;
                so      <= 1'b0;
            end else begin
                if (!paused && !hold_n && !sck)
                    paused <= 1'b1;
                else if (paused && hold_n && !sck)
                    paused <= 1'b0;
                if (rise) begin
                    rx_sh   <= {rx_sh[6:0], si};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {rx_sh[6:0], si};
                    end
                end
                if (fall) begin
                    if (bit_cnt == 3'd0) begin
                        so    <= tx_byte[7];
                        tx_sh <= {tx_byte[6:0], 1'b0};
                    end else begin
                        so    <= tx_sh[7];
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_eeprom_page.sv
// Page buffer with per-byte valid mask, flush to the array and busy timer.
module spi_eeprom_page #(
    parameter int AW         = 15,
    parameter int PAGE_BYTES = 64,
    parameter int WR_CYCLES  = 500000,
    localparam int PW = $clog2(PAGE_BYTES),
    localparam int CW = $clog2(WR_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic [PW-1:0] ld_idx,
    input  logic [7:0]    ld_data,
    input  logic          start,
    input  logic [AW-PW-1:0] page,
    output logic          busy,
    output logic          done,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask;
    logic [CW-1:0]         cnt;
    logic [AW-PW-1:0]      base;
    logic                  flushing;
    logic [PW-1:0]         fidx;

    assign fidx     = cnt[PW-1:0];
    assign flushing = busy && (cnt < CW'(PAGE_BYTES));
    assign wr_en    = flushing && mask[fidx];
    assign wr_addr  = {base, fidx};
    assign wr_data  = pbuf[fidx];

    always_ff @(posedge clk) begin
        if (ld)
            pbuf[ld_idx] <= ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            base <= '0;
        end else begin
            done <= 1'b0;
            if (clr)
                mask <= '0;
            else if (ld)
                mask[ld_idx] <= 1'b1;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
                base <= page;
            end else if (busy) begin
                if (cnt == CW'(WR_CYCLES - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_eeprom_slave.sv
// Command decoder, status register and array port for the serial EEPROM slave.
module spi_eeprom_slave
    import spi_eeprom_pkg::*;
#(
    parameter int MEM_BYTES  = 32768,
    parameter int PAGE_BYTES = 64,
    parameter int WR_CYCLES  = 500000,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          si,
    input  logic          hold_n,
    input  logic          wp_n,
    output logic          so,
    output logic          so_oe,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    cmd_state_t    state, nxt;
    logic [7:0]    rx_byte, tx_byte, cmd, addr_hi;
    logic          byte_done, live, so_bit;
    logic [2:0]    bit_cnt;
    logic [AW-1:0] addr, pg_addr, ld_addr;
    logic [PW-1:0] pidx;
    logic          got, wel, wpen, cs_q;
    logic [1:0]    bp;
    logic          busy, wr_done, pg_ld, pg_clr, pg_start;
    logic          sr_lock, cs_rise;

    function automatic logic is_prot(input logic [AW-1:0] a, input logic [1:0] code);
        unique case (code)
            2'b00:   return 1'b0;
            2'b01:   return &a[AW-1:AW-2];
            2'b10:   return a[AW-1];
            default: return 1'b1;
        endcase
    endfunction

    spi_eeprom_shift u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .byte_done(byte_done),
        .bit_cnt(bit_cnt), .so(so_bit), .live(live)
    );

    assign sr_lock  = wpen && !wp_n;
    assign cs_rise  = cs_n && !cs_q;
    assign ld_addr  = {addr[AW-1:PW], pidx};
    assign pg_ld    = byte_done && !cs_n && (state == ST_DATA_IN) && !is_prot(ld_addr, bp);
    assign pg_clr   = byte_done && !cs_n && (state == ST_ADDR_LO);
    assign pg_start = cs_rise && (state == ST_DATA_IN) && got && (bit_cnt == 3'd0);

    spi_eeprom_page #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_page (
        .clk(clk), .rst_n(rst_n), .clr(pg_clr), .ld(pg_ld), .ld_idx(pidx),
        .ld_data(rx_byte), .start(pg_start), .page(addr[AW-1:PW]),
        .busy(busy), .done(wr_done), .wr_en(mem_we), .wr_addr(pg_addr),
        .wr_data(mem_wdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= nxt;
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        if (cs_n) begin
            nxt = ST_CMD;
        end else if (byte_done) begin
            unique case (state)
                ST_CMD: begin
                    if (rx_byte == OP_RDSR)                 nxt = ST_STAT_RD;
                    else if (busy)                          nxt = ST_SKIP;
                    else if (rx_byte == OP_READ)            nxt = ST_ADDR_HI;
                    else if (rx_byte == OP_WRITE && wel)    nxt = ST_ADDR_HI;
                    else if (rx_byte == OP_WRSR && wel)     nxt = ST_STAT_WR;
                    else                                    nxt = ST_SKIP;
                end
                ST_ADDR_HI: nxt = ST_ADDR_LO;
                ST_ADDR_LO: nxt = (cmd == OP_READ) ? ST_READ : ST_DATA_IN;
                ST_STAT_WR: nxt = ST_SKIP;
                default:    nxt = state;
            endcase
        end
    end

    // Datapath and status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd     <= '0;
            addr_hi <= '0;
            addr    <= '0;
            pidx    <= '0;
            got     <= 1'b0;
            wel     <= 1'b0;
            wpen    <= 1'b0;
            bp      <= '0;
            cs_q    <= 1'b1;
        end else begin
            cs_q <= cs_n;
            if (!cs_n && byte_done) begin
                case (state)
                    ST_CMD: begin
                        cmd <= rx_byte;
                        if (!busy && rx_byte == OP_WREN) wel <= 1'b1;
                        if (!busy && rx_byte == OP_WRDI) wel <= 1'b0;
                    end
                    ST_ADDR_HI: addr_hi <= rx_byte;
                    ST_ADDR_LO: begin
                        addr <= AW'({addr_hi, rx_byte});
                        pidx <= rx_byte[PW-1:0];
                        got  <= 1'b0;
                    end
                    ST_READ: addr <= addr + 1'b1;
                    ST_DATA_IN: begin
                        pidx <= pidx + 1'b1;
                        got  <= 1'b1;
                    end
                    ST_STAT_WR: begin
                        if (!sr_lock) begin
                            wpen <= rx_byte[7];
                            bp   <= rx_byte[3:2];
                            wel  <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (wr_done)
                wel <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        tx_byte  = (state == ST_STAT_RD) ? {wpen, 3'b000, bp, wel, busy} : mem_rdata;
        so_oe    = live && (state == ST_READ || state == ST_STAT_RD);
        so       = so_bit;
        mem_addr = busy ? pg_addr : addr;
    end
endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk
    import spi_eeprom_pkg::*;
#(
    parameter int AW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          sck,
    input logic          hold_n,
    input logic          wp_n,
    input logic          so_oe,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          wel,
    input logic          wpen,
    input logic [1:0]    bp,
    input logic          byte_done,
    input logic [7:0]    rx_byte,
    input cmd_state_t    state
);
    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_oe);

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_done && !cs_n && state == ST_CMD && rx_byte != OP_RDSR) |=> state == ST_SKIP);

    // R7
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !wel);

    // R11
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !hold_n && !sck) |=> !so_oe);

    // R10
    status_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wpen && !wp_n) |=> (wpen && bp == $past(bp)));

    // R8
    protect_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(bp == 2'b11 || (bp == 2'b10 && mem_addr[AW-1]) ||
                     (bp == 2'b01 && (&mem_addr[AW-1:AW-2]))));
endmodule

bind spi_eeprom_slave spi_eeprom_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n), .wp_n(wp_n),
    .so_oe(so_oe), .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy), .wel(wel),
    .wpen(wpen), .bp(bp), .byte_done(byte_done), .rx_byte(rx_byte), .state(state)
);

// File: tb/spi_eeprom_slave_test.sv
module spi_eeprom_slave_test;
    localparam int MEMB = 1024;
    localparam int AWT  = 10;
    localparam int H    = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, cs_n, sck, si, hold_n, wp_n, so, so_oe, mem_we, mode3;
    logic [AWT-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic [7:0] mem [MEMB];
    int n_chk = 0;
    int n_bad = 0;

    spi_eeprom_slave #(.MEM_BYTES(MEMB), .PAGE_BYTES(64), .WR_CYCLES(200)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .wp_n(wp_n), .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic o);
        sck = 1'b0;
        si  = b;
        tick(H);
        o   = so;
        sck = 1'b1;
        tick(H);
        if (!mode3) sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic t;
            spi_bit(b[i], t);
            r[i] = t;
        end
    endtask

    task automatic cs_begin();
        sck  = mode3;
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic cs_end();
        tick(H);
        cs_n = 1'b1;
        sck  = mode3;
        tick(2 * H);
    endtask

    task automatic send_cmd(input logic [7:0] op);
        logic [7:0] d;
        cs_begin(); spi_byte(op, d); cs_end();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        cs_begin(); spi_byte(8'h05, d); spi_byte(8'h00, s); cs_end();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        cs_begin(); spi_byte(8'h01, d); spi_byte(v, d); cs_end();
    endtask

    task automatic read2(input logic [15:0] a, output logic [7:0] b0, output logic [7:0] b1);
        logic [7:0] d;
        cs_begin();
        spi_byte(8'h03, d); spi_byte(a[15:8], d); spi_byte(a[7:0], d);
        spi_byte(8'h00, b0); spi_byte(8'h00, b1);
        cs_end();
    endtask

    task automatic write_n(input logic [15:0] a, input int n, input logic [31:0] dat);
        logic [7:0] d;
        cs_begin();
        spi_byte(8'h02, d); spi_byte(a[15:8], d); spi_byte(a[7:0], d);
        for (int k = 0; k < n; k++) spi_byte(dat[31-8*k -: 8], d);
        cs_end();
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic t_reset();
        logic [7:0] s;
        check({7'd0, so_oe}, 8'h00, "R2 so_oe idle");
        check({7'd0, mem_we}, 8'h00, "R2 no write at reset");
        rdsr(s);
        check(s, 8'h00, "R3 status after reset");
    endtask

    task automatic t_latch();
        logic [7:0] s;
        send_cmd(8'h06); rdsr(s); check(s, 8'h02, "R3 latch set");
        send_cmd(8'h04); rdsr(s); check(s, 8'h00, "R3 latch cleared");
    endtask

    task automatic t_write_no_latch();
        logic [7:0] a, b, s;
        write_n(16'h0010, 1, 32'h11000000);
        rdsr(s); check(s, 8'h00, "R5 no cycle started");
        read2(16'h0010, a, b); check(a, pat(16'h10), "R5 byte unchanged");
    endtask

    task automatic t_write_basic();
        logic [7:0] a, b, s;
        send_cmd(8'h06);
        write_n(16'h0010, 2, 32'hA53C0000);
        rdsr(s); check(s, 8'h03, "R7 busy and latch during cycle");
        wait_ready();
        rdsr(s); check(s, 8'h00, "R7 latch cleared after cycle");
        read2(16'h0010, a, b);
        check(a, 8'hA5, "R4 R6 first byte"); check(b, 8'h3C, "R4 R6 second byte");
    endtask

    task automatic t_busy_ignore();
        logic [7:0] a, b;
        send_cmd(8'h06);
        write_n(16'h0020, 1, 32'h77000000);
        write_n(16'h0021, 1, 32'h88000000);
        wait_ready();
        read2(16'h0020, a, b);
        check(a, 8'h77, "R7 first write done"); check(b, pat(16'h21), "R7 write during busy ignored");
    endtask

    task automatic t_page_wrap();
        logic [7:0] a, b;
        send_cmd(8'h06);
        write_n(16'h007E, 4, 32'h01020304);
        wait_ready();
        read2(16'h007E, a, b);
        check(a, 8'h01, "R6 page byte 0x7E"); check(b, 8'h02, "R6 page byte 0x7F");
        read2(16'h0040, a, b);
        check(a, 8'h03, "R6 wrapped to 0x40"); check(b, 8'h04, "R6 wrapped to 0x41");
        read2(16'h0080, a, b); check(a, pat(16'h80), "R6 next page untouched");
    endtask

    task automatic t_partial();
        logic [7:0] a, b, s, d;
        logic t;
        send_cmd(8'h06);
        cs_begin();
        spi_byte(8'h02, d); spi_byte(8'h00, d); spi_byte(8'hC0, d); spi_byte(8'h99, d);
        spi_bit(1'b1, t); spi_bit(1'b0, t); spi_bit(1'b1, t);
        cs_end();
        rdsr(s); check(s, 8'h02, "R6 partial byte: no cycle, latch kept");
        read2(16'h00C0, a, b); check(a, pat(16'hC0), "R6 partial byte writes nothing");
        send_cmd(8'h04);
    endtask

    task automatic t_seq_wrap();
        logic [7:0] a, b;
        read2(16'h03FF, a, b);
        check(a, pat(16'h3FF), "R4 last byte"); check(b, pat(0), "R4 wrap to address 0");
    endtask

    task automatic prot_write(input logic [15:0] adr, input logic [7:0] v, input logic [7:0] exp,
                              input string tag);
        logic [7:0] a, b;
        send_cmd(8'h06);
        write_n(adr, 1, {v, 24'd0});
        wait_ready();
        read2(adr, a, b);
        check(a, exp, tag);
    endtask

    task automatic t_protect();
        logic [7:0] s;
        send_cmd(8'h06); wrsr(8'h04);
        rdsr(s); check(s, 8'h04, "R9 status written, latch cleared");
        prot_write(16'h0300, 8'hE1, pat(16'h300), "R8 quarter protected");
        prot_write(16'h02FF, 8'hE2, 8'hE2, "R8 below quarter writable");
        send_cmd(8'h06); wrsr(8'h08);
        prot_write(16'h0200, 8'hE3, pat(16'h200), "R8 half protected");
        prot_write(16'h01FF, 8'hE4, 8'hE4, "R8 below half writable");
        send_cmd(8'h06); wrsr(8'h0C);
        prot_write(16'h0000, 8'hE5, pat(0), "R8 whole array protected");
        send_cmd(8'h06); wrsr(8'h00);
        rdsr(s); check(s, 8'h00, "R9 protection removed");
    endtask

    task automatic t_wp();
        logic [7:0] s;
        wrsr(8'h0C); rdsr(s); check(s, 8'h00, "R9 status write needs latch");
        send_cmd(8'h06); wrsr(8'h80);
        rdsr(s); check(s, 8'h80, "R9 protect-enable set");
        wp_n = 1'b0;
        send_cmd(8'h06); wrsr(8'h0C);
        rdsr(s); check(s, 8'h82, "R10 locked status rejected");
        wp_n = 1'b1;
        wrsr(8'h00);
        rdsr(s); check(s, 8'h00, "R10 unlocked with WP high");
        wp_n = 1'b0;
        send_cmd(8'h06); wrsr(8'h08);
        rdsr(s); check(s, 8'h08, "R10 WP ignored without protect-enable");
        send_cmd(8'h06); wrsr(8'h00);
        wp_n = 1'b1;
    endtask

    task automatic t_mode3();
        logic [7:0] a, b, s;
        mode3 = 1'b1;
        sck   = 1'b1;
        tick(2 * H);
        read2(16'h0010, a, b);
        check(a, 8'hA5, "R1 mode 3 read byte 0"); check(b, 8'h3C, "R1 mode 3 read byte 1");
        rdsr(s); check(s, 8'h00, "R1 mode 3 status");
        mode3 = 1'b0;
        sck   = 1'b0;
        tick(2 * H);
    endtask

    task automatic t_hold();
        logic [7:0] d, r, r2;
        logic t;
        cs_begin();
        spi_byte(8'h03, d); spi_byte(8'h00, d); spi_byte(8'h10, d);
        for (int i = 7; i >= 5; i--) begin spi_bit(1'b0, t); r[i] = t; end
        hold_n = 1'b0;
        tick(H);
        check({7'd0, so_oe}, 8'h00, "R11 output released while paused");
        si = 1'b1;
        for (int k = 0; k < 2; k++) begin sck = 1'b1; tick(H); sck = 1'b0; tick(H); end
        check({7'd0, so_oe}, 8'h00, "R11 still paused after SCK toggles");
        hold_n = 1'b1;
        tick(H);
        for (int i = 4; i >= 0; i--) begin spi_bit(1'b0, t); r[i] = t; end
        spi_byte(8'h00, r2);
        cs_end();
        check(r, 8'hA5, "R12 byte continues across pause");
        check(r2, 8'h3C, "R12 next byte in sequence");
    endtask

    initial begin
        for (int i = 0; i < MEMB; i++) mem[i] = pat(i);
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
        hold_n = 1'b1; wp_n = 1'b1; mode3 = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_latch();
        t_write_no_latch();
        t_write_basic();
        t_busy_ignore();
        t_page_wrap();
        t_partial();
        t_seq_wrap();
        t_protect();
        t_wp();
        t_mode3();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule